// File: doc/BRIEF.md
# SDRAM Bank Timing Guard

This block keeps track of the timing state of a four-bank synchronous DRAM. A memory controller tells it each command it issues: the command class and the bank. It also tells the block when the last beat of write data reaches a bank. From this the block keeps one set of countdown timers per bank and a few timers shared by all banks. It reports, for every bank and command class, whether that command may legally go out in the current cycle.

All timing limits are parameters in nanoseconds, apart from the two limits that are defined in clocks. At elaboration they are turned into clock counts by rounding up against the clock-period parameter. The scheduler in front of the block only has to AND its candidates with the allow flags.

The block also has a row-open limit flag. This tells the scheduler that a row must be closed. A sticky violation record holds the bank and class of the first command that went out while its allow flag was low.

Top module: `sdram_timing_guard`

## Requirements
- R1: After reset, every bank is closed. Activate and precharge are allowed on all banks, and column access is allowed on none. Refresh, mode set and burst stop are allowed. No row-limit flag and no violation are raised.
- R2: A read or write to a bank is allowed only while its row is open and at least the row-to-column delay has passed since that bank's activate. A precharge to the bank removes column permission in the next cycle.
- R3: Precharge of a bank is allowed only when both of these hold: the minimum row-active time has passed since its activate, and the write-recovery time has passed since its last write data.
- R4: Activate of a bank is allowed only when all of these hold: the bank is closed, the precharge time has passed since its precharge, the row cycle time has passed since its activate or since a refresh, and one clock plus the precharge time has passed since its last write data.
- R5: After an activate to any bank, no activate to any bank is allowed until the activate-to-activate spacing has elapsed.
- R6: row_expired of a bank goes high once its row has stayed open for the maximum row-active time. It clears when the bank is precharged.
- R7: After a mode register set, no command of any class is allowed until the mode-set recovery clocks (default 2) have passed.
- R8: Burst stop is allowed only once the burst-stop clocks (default 1) have passed since the last write data of any bank.
- R9: Refresh and mode register set are allowed only when every bank is closed and every bank's activate timing is satisfied. A refresh restarts the row-cycle hold-off on all banks.
- R10: A command issued while its allow flag is low sets viol_flag. It records the bank and the command code, with the codes ACT=0, RD=1, WR=2, PRE=3, REF=4, MRS=5, BST=6 and NOP=7. Only the first violation is kept, until reset. Legal commands never set the flag.
- R11: Each nanosecond limit becomes ceil(limit / clock period) clocks. For example, a 16 ns spacing at a 5 ns clock is 4 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_kind | input | 3 | Command code (see R10) |
| cmd_bank | input | 2 | Target bank of the command |
| wlast_valid | input | 1 | Last write data beat reaches a bank this cycle |
| wlast_bank | input | 2 | Bank receiving that last beat |
| allow_act | output | 4 | Per-bank activate permission |
| allow_col | output | 4 | Per-bank read/write permission |
| allow_pre | output | 4 | Per-bank precharge permission |
| allow_ref | output | 1 | Refresh permission |
| allow_mrs | output | 1 | Mode register set permission |
| allow_bst | output | 1 | Burst stop permission |
| row_expired | output | 4 | Per-bank maximum row-open time reached |
| viol_flag | output | 1 | Sticky illegal-command flag |
| viol_bank | output | 2 | Bank of the first illegal command |
| viol_kind | output | 3 | Code of the first illegal command |

## Verification
The assertions assume that at most one command arrives per cycle. They also assume that the mode-set, activate-spacing and row-to-column counts exceed one clock, so that a one-cycle blocking window can be seen at the flags. The bench overrides the clock period to 5 ns so that all of these counts, the write recovery and the burst-stop count are at least two clocks. Every stimulus issues one command at a time, and write-last beats are driven on separate cycles from commands. Each illegal command the bench issues is deliberate and sits in the violation scenario.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
  typedef enum logic [2:0] {
    CMD_ACT = 3'd0,
    CMD_RD  = 3'd1,
    CMD_WR  = 3'd2,
    CMD_PRE = 3'd3,
    CMD_REF = 3'd4,
    CMD_MRS = 3'd5,
    CMD_BST = 3'd6,
    CMD_NOP = 3'd7
  } cmd_e;

  // clocks covering a nanosecond limit, rounded up
  function automatic int ns2ck(input int ns, input int tck);
    return (ns + tck - 1) / tck;
  endfunction

  // counter load value for a wait of n clocks
  function automatic int ck2ld(input int n);
    return (n > 0) ? n - 1 : 0;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sdt_holdoff.sv
module sdt_holdoff #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          ready
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] dec;

  assign dec = (cnt != '0) ? cnt - 1'b1 : '0;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load && load_val > dec) cnt <= load_val;
    else cnt <= dec;
  end

  assign ready = (cnt == '0);
endmodule

// File: rtl/sdt_bank.sv
module sdt_bank #(
  parameter int CW    = 4,
  parameter int RCD_L = 0,
  parameter int RP_L  = 0,
  parameter int RAS_L = 0,
  parameter int RC_L  = 0,
  parameter int WR_L  = 0,
  parameter int WRA_L = 0,
  parameter int RMAX  = 16,
  parameter int OW    = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic act,
  input  logic pre,
  input  logic wlast,
  input  logic refr,
  output logic is_open,
  output logic col_ok,
  output logic pre_ok,
  output logic act_ok,
  output logic expired
);
  logic [CW-1:0] act_val, pre_val;
  logic [OW-1:0] age;

  always_comb begin
    act_val = '0;
    if (act || refr) act_val = CW'(RC_L);
    if (pre && CW'(RP_L) > act_val) act_val = CW'(RP_L);
    if (wlast && CW'(WRA_L) > act_val) act_val = CW'(WRA_L);
  end

  always_comb begin
    pre_val = '0;
    if (act) pre_val = CW'(RAS_L);
    if (wlast && CW'(WR_L) > pre_val) pre_val = CW'(WR_L);
  end

  sdt_holdoff #(.CW(CW)) u_rcd (
    .clk(clk), .rst(rst), .load(act), .load_val(CW'(RCD_L)), .ready(col_ok)
  );

  sdt_holdoff #(.CW(CW)) u_pre (
    .clk(clk), .rst(rst), .load(act || wlast), .load_val(pre_val), .ready(pre_ok)
  );

  sdt_holdoff #(.CW(CW)) u_act (
    .clk(clk), .rst(rst), .load(act || pre || wlast || refr),
    .load_val(act_val), .ready(act_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      is_open <= 1'b0;
      age     <= '0;
    end else if (act) begin
      is_open <= 1'b1;
      age     <= OW'(1);
    end else if (pre) begin
      is_open <= 1'b0;
      age     <= '0;
    end else if (is_open && age != OW'(RMAX)) begin
      age <= age + 1'b1;
    end
  end

  assign expired = is_open && (age == OW'(RMAX));
endmodule

// File: rtl/sdt_viol.sv
module sdt_viol #(
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic [BW-1:0] bank,
  input  logic [2:0]    kind,
  output logic          flag,
  output logic [BW-1:0] flag_bank,
  output logic [2:0]    flag_kind
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag      <= 1'b0;
      flag_bank <= '0;
      flag_kind <= '0;
    end else if (hit && !flag) begin
      flag      <= 1'b1;
      flag_bank <= bank;
      flag_kind <= kind;
    end
  end
endmodule

// File: rtl/sdram_timing_guard.sv
module sdram_timing_guard #(
  parameter int NUM_BANKS    = 4,
  parameter int T_CK_NS      = 8,
  parameter int T_RCD_NS     = 20,
  parameter int T_RP_NS      = 20,
  parameter int T_RAS_NS     = 48,
  parameter int T_RAS_MAX_NS = 120000,
  parameter int T_RC_NS      = 70,
  parameter int T_RRD_NS     = 16,
  parameter int T_WR_NS      = 8,
  parameter int T_MRD_CK     = 2,
  parameter int T_BDL_CK     = 1,
  localparam int BW          = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_kind,
  input  logic [BW-1:0]        cmd_bank,
  input  logic                 wlast_valid,
  input  logic [BW-1:0]        wlast_bank,
  output logic [NUM_BANKS-1:0] allow_act,
  output logic [NUM_BANKS-1:0] allow_col,
  output logic [NUM_BANKS-1:0] allow_pre,
  output logic                 allow_ref,
  output logic                 allow_mrs,
  output logic                 allow_bst,
  output logic [NUM_BANKS-1:0] row_expired,
  output logic                 viol_flag,
  output logic [BW-1:0]        viol_bank,
  output logic [2:0]           viol_kind
);
  import sdt_pkg::*;

  localparam int RCD_L = ck2ld(ns2ck(T_RCD_NS, T_CK_NS));
  localparam int RP_CK = ns2ck(T_RP_NS, T_CK_NS);
  localparam int RP_L  = ck2ld(RP_CK);
  localparam int RAS_L = ck2ld(ns2ck(T_RAS_NS, T_CK_NS));
  localparam int RC_L  = ck2ld(ns2ck(T_RC_NS, T_CK_NS));
  localparam int RRD_L = ck2ld(ns2ck(T_RRD_NS, T_CK_NS));
  localparam int WR_L  = ck2ld(ns2ck(T_WR_NS, T_CK_NS));
  localparam int WRA_L = ck2ld(1 + RP_CK);
  localparam int MRD_L = ck2ld(T_MRD_CK);
  localparam int BDL_L = ck2ld(T_BDL_CK);
  localparam int RMAX  = ns2ck(T_RAS_MAX_NS, T_CK_NS);
  localparam int OW    = $clog2(RMAX + 1);
  localparam int MAXL  = max2(max2(max2(RCD_L, RP_L), max2(RAS_L, RC_L)),
                              max2(max2(RRD_L, WR_L), max2(WRA_L, max2(MRD_L, BDL_L))));
  localparam int CW    = $clog2(MAXL + 2);

  logic [NUM_BANKS-1:0] b_act, b_pre, b_wl, b_open, b_col, b_pre_ok, b_act_ok;
  logic is_act, is_ref, is_mrs, rrd_ok, mrd_ok, bdl_ok, all_idle, legal;

  assign is_act = cmd_valid && cmd_kind == CMD_ACT;
  assign is_ref = cmd_valid && cmd_kind == CMD_REF;
  assign is_mrs = cmd_valid && cmd_kind == CMD_MRS;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    assign b_act[i] = is_act && cmd_bank == BW'(i);
    assign b_pre[i] = cmd_valid && cmd_kind == CMD_PRE && cmd_bank == BW'(i);
    assign b_wl[i]  = wlast_valid && wlast_bank == BW'(i);

    sdt_bank #(
      .CW(CW), .RCD_L(RCD_L), .RP_L(RP_L), .RAS_L(RAS_L), .RC_L(RC_L),
      .WR_L(WR_L), .WRA_L(WRA_L), .RMAX(RMAX), .OW(OW)
    ) u_bank (
      .clk(clk), .rst(rst), .act(b_act[i]), .pre(b_pre[i]), .wlast(b_wl[i]),
      .refr(is_ref), .is_open(b_open[i]), .col_ok(b_col[i]),
      .pre_ok(b_pre_ok[i]), .act_ok(b_act_ok[i]), .expired(row_expired[i])
    );

    assign allow_act[i] = !b_open[i] && b_act_ok[i] && rrd_ok && mrd_ok;
    assign allow_col[i] = b_open[i] && b_col[i] && mrd_ok;
    assign allow_pre[i] = b_pre_ok[i] && mrd_ok;
  end

  sdt_holdoff #(.CW(CW)) u_rrd (
    .clk(clk), .rst(rst), .load(is_act), .load_val(CW'(RRD_L)), .ready(rrd_ok)
  );
  sdt_holdoff #(.CW(CW)) u_mrd (
    .clk(clk), .rst(rst), .load(is_mrs), .load_val(CW'(MRD_L)), .ready(mrd_ok)
  );
  sdt_holdoff #(.CW(CW)) u_bdl (
    .clk(clk), .rst(rst), .load(wlast_valid), .load_val(CW'(BDL_L)), .ready(bdl_ok)
  );

  assign all_idle  = (b_open == '0) && (&b_act_ok);
  assign allow_ref = all_idle && mrd_ok;
  assign allow_mrs = all_idle && mrd_ok;
  assign allow_bst = bdl_ok && mrd_ok;

  always_comb begin
    case (cmd_kind)
      CMD_ACT:         legal = allow_act[cmd_bank];
      CMD_RD, CMD_WR:  legal = allow_col[cmd_bank];
      CMD_PRE:         legal = allow_pre[cmd_bank];
      CMD_REF:         legal = allow_ref;
      CMD_MRS:         legal = allow_mrs;
      CMD_BST:         legal = allow_bst;
      default:         legal = 1'b1;
    endcase
  end

  sdt_viol #(.BW(BW)) u_viol (
    .clk(clk), .rst(rst), .hit(cmd_valid && !legal), .bank(cmd_bank),
    .kind(cmd_kind), .flag(viol_flag), .flag_bank(viol_bank), .flag_kind(viol_kind)
  );
endmodule

// File: rtl/sdt_checker.sv
module sdt_checker #(
  parameter int NUM_BANKS = 4,
  parameter int T_CK_NS   = 8,
  parameter int T_RCD_NS  = 20,
  parameter int T_RRD_NS  = 16,
  parameter int T_MRD_CK  = 2,
  localparam int BW       = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cmd_valid,
  input logic [2:0]           cmd_kind,
  input logic [BW-1:0]        cmd_bank,
  input logic [NUM_BANKS-1:0] allow_act,
  input logic [NUM_BANKS-1:0] allow_col,
  input logic                 allow_ref,
  input logic                 allow_mrs,
  input logic [NUM_BANKS-1:0] row_expired,
  input logic                 viol_flag,
  input logic [BW-1:0]        viol_bank,
  input logic [2:0]           viol_kind
);
  localparam int RCD_CK = sdt_pkg::ns2ck(T_RCD_NS, T_CK_NS);
  localparam int RRD_CK = sdt_pkg::ns2ck(T_RRD_NS, T_CK_NS);

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_b
    if (RCD_CK > 1) begin : g_rcd
      p_col_wait_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 3'd0 && cmd_bank == BW'(i)) |=> !allow_col[i]);
    end
    p_pre_shuts_col_r2: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_kind == 3'd3 && cmd_bank == BW'(i)) |=> !allow_col[i]);
    p_expired_is_open_r6: assert property (@(posedge clk) disable iff (rst)
      row_expired[i] |-> !allow_act[i]);
  end

  if (RRD_CK > 1) begin : g_rrd
    p_act_spacing_r5: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_kind == 3'd0) |=> (allow_act == '0));
  end

  if (T_MRD_CK > 1) begin : g_mrd
    p_mrs_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_kind == 3'd5) |=> (allow_act == '0 && !allow_ref && !allow_mrs));
  end

  p_viol_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    viol_flag |=> (viol_flag && $stable(viol_bank) && $stable(viol_kind)));
endmodule

bind sdram_timing_guard sdt_checker #(
  .NUM_BANKS(NUM_BANKS), .T_CK_NS(T_CK_NS), .T_RCD_NS(T_RCD_NS),
  .T_RRD_NS(T_RRD_NS), .T_MRD_CK(T_MRD_CK)
) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
  .cmd_bank(cmd_bank), .allow_act(allow_act), .allow_col(allow_col),
  .allow_ref(allow_ref), .allow_mrs(allow_mrs), .row_expired(row_expired),
  .viol_flag(viol_flag), .viol_bank(viol_bank), .viol_kind(viol_kind)
);

// File: tb/sdram_timing_guard_bench.sv
module sdram_timing_guard_bench;
  localparam int CLK_PERIOD = 10;
  // bench clock period parameter 5 ns: RCD 4, RP 4, RAS 10, RC 14, RRD 4,
  // WR 2, write-to-activate 5, MRD 2, burst stop 2, row limit 24000 clocks
  localparam logic [2:0] K_ACT = 3'd0, K_RD = 3'd1, K_PRE = 3'd3,
                         K_REF = 3'd4, K_MRS = 3'd5, K_NOP = 3'd7;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, wlast_valid = 1'b0;
  logic [2:0] cmd_kind = K_NOP;
  logic [1:0] cmd_bank = '0, wlast_bank = '0;
  logic [3:0] allow_act, allow_col, allow_pre, row_expired;
  logic allow_ref, allow_mrs, allow_bst, viol_flag;
  logic [1:0] viol_bank;
  logic [2:0] viol_kind;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_timing_guard #(.T_CK_NS(5), .T_BDL_CK(2)) u_sdram_timing_guard (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_bank(cmd_bank), .wlast_valid(wlast_valid), .wlast_bank(wlast_bank),
    .allow_act(allow_act), .allow_col(allow_col), .allow_pre(allow_pre),
    .allow_ref(allow_ref), .allow_mrs(allow_mrs), .allow_bst(allow_bst),
    .row_expired(row_expired), .viol_flag(viol_flag), .viol_bank(viol_bank),
    .viol_kind(viol_kind)
  );

  task automatic ck(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic issue(input logic [2:0] k, input logic [1:0] b);
    cmd_valid = 1'b1; cmd_kind = k; cmd_bank = b;
    tick();
    cmd_valid = 1'b0; cmd_kind = K_NOP;
  endtask

  task automatic wdone(input logic [1:0] b);
    wlast_valid = 1'b1; wlast_bank = b;
    tick();
    wlast_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    ck("R1 act", allow_act, 4'hF);
    ck("R1 col", allow_col, 4'h0);
    ck("R1 pre", allow_pre, 4'hF);
    ck("R1 ref/mrs/bst", {allow_ref, allow_mrs, allow_bst}, 3'b111);
    ck("R1 expired", row_expired, 0);
    ck("R1 viol", viol_flag, 0);
  endtask

  task automatic t_rcd_rrd();
    do_reset();
    issue(K_ACT, 2'd0);                  // cycle t, now t+1
    ck("R2 col t+1", allow_col[0], 0);
    ck("R5 act other t+1", allow_act[1], 0);
    idle(2);                             // t+3
    ck("R2 col t+3", allow_col[0], 0);
    ck("R11 act other t+3 (16ns/5ns -> 4)", allow_act[1], 0);
    tick();                              // t+4
    ck("R2 col t+4", allow_col[0], 1);
    ck("R5 act other t+4", allow_act[1], 1);
    ck("R4 act same bank open", allow_act[0], 0);
    ck("R10 no viol on legal", viol_flag, 0);
  endtask

  task automatic t_pre_write();
    do_reset();
    issue(K_ACT, 2'd0);                  // t+1
    idle(8);                             // t+9
    ck("R3 pre t+9", allow_pre[0], 0);
    tick();                              // t+10
    ck("R3 pre t+10", allow_pre[0], 1);
    wdone(2'd0);                         // u=t+10, now u+1
    ck("R3 pre after wlast u+1", allow_pre[0], 0);
    ck("R8 bst u+1", allow_bst, 0);
    tick();                              // u+2
    ck("R3 pre after wlast u+2", allow_pre[0], 1);
    ck("R8 bst u+2", allow_bst, 1);
    issue(K_PRE, 2'd0);                  // p=u+2, now p+1
    ck("R2 col after pre", allow_col[0], 0);
    idle(2);                             // p+3 (= u+5)
    ck("R4 act p+3", allow_act[0], 0);
    tick();                              // p+4
    ck("R4 act p+4", allow_act[0], 1);
    ck("R10 no viol", viol_flag, 0);
  endtask

  task automatic t_rc();
    do_reset();
    issue(K_ACT, 2'd1);                  // t+1
    idle(9);                             // t+10
    issue(K_PRE, 2'd1);                  // t+11
    idle(2);                             // t+13
    ck("R4 act t+13", allow_act[1], 0);
    tick();                              // t+14
    ck("R4 act t+14", allow_act[1], 1);
  endtask

  task automatic t_refresh();
    do_reset();
    issue(K_ACT, 2'd2);                  // t+1
    ck("R9 ref with open bank", allow_ref, 0);
    ck("R9 mrs with open bank", allow_mrs, 0);
    idle(9);                             // t+10
    issue(K_PRE, 2'd2);                  // t+11
    idle(2);                             // t+13
    ck("R9 ref during rp", allow_ref, 0);
    tick();                              // t+14
    ck("R9 ref ready", allow_ref, 1);
    ck("R9 mrs ready", allow_mrs, 1);
    issue(K_REF, 2'd0);                  // q, now q+1
    ck("R9 act after ref q+1", allow_act, 4'h0);
    idle(12);                            // q+13
    ck("R9 act q+13", allow_act[0], 0);
    tick();                              // q+14
    ck("R9 act q+14", allow_act, 4'hF);
  endtask

  task automatic t_mrs();
    do_reset();
    issue(K_MRS, 2'd0);                  // t+1
    ck("R7 act t+1", allow_act, 0);
    ck("R7 pre t+1", allow_pre, 0);
    ck("R7 ref/mrs/bst t+1", {allow_ref, allow_mrs, allow_bst}, 0);
    tick();                              // t+2
    ck("R7 act t+2", allow_act, 4'hF);
    ck("R7 ref t+2", allow_ref, 1);
  endtask

  task automatic t_expire();
    do_reset();
    issue(K_ACT, 2'd3);                  // t+1
    idle(23998);                         // t+23999
    ck("R6 before limit", row_expired, 0);
    tick();                              // t+24000
    ck("R6 at limit", row_expired, 4'h8);
    issue(K_PRE, 2'd3);
    ck("R6 cleared by pre", row_expired, 0);
  endtask

  task automatic t_violation();
    do_reset();
    issue(K_RD, 2'd3);
    ck("R10 flag", viol_flag, 1);
    ck("R10 bank", viol_bank, 3);
    ck("R10 kind RD=1", viol_kind, 1);
    issue(K_ACT, 2'd3);
    issue(K_ACT, 2'd3);                  // illegal again, not recorded
    ck("R10 first kept kind", viol_kind, 1);
    ck("R10 first kept bank", viol_bank, 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_rcd_rrd();
    t_pre_write();
    t_rc();
    t_refresh();
    t_mrs();
    t_violation();
    t_expire();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule